// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block runs one complete page-program operation on an asynchronous 8-bit NAND flash bus. A single `start` pulse opens the operation. The block keeps chip enable low and issues the program-setup command. It then issues five address bytes, which carry a two-byte column and a three-byte row. Next it streams one page of data bytes and issues the confirm command. It waits a fixed settle time and polls the ready/busy line until the device is ready again. Finally it reads the status byte and reports whether the program succeeded.

The block keeps no page buffer of its own. For each data byte it raises a one-cycle request to an external byte mover, for example a DMA channel walking a circular buffer. It then waits for that mover to pulse `byte_done` with the byte on `byte_in`. Only after that does it strobe write-enable for the byte. Every strobe width comes from a count of system-clock cycles, so the bus runs correctly from a slow clock of a few MHz. Because each operation consumes exactly one page of bytes, a circular source falls back to its buffer start on its own. The next operation then needs no setup.

Top module: `nand_pgm_seq`

## Requirements
- R1: After reset the block is idle: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `busy`, `done` and `byte_req` are low, and no write strobe occurs.
- R2: `start` is taken only while idle. `busy` rises in the cycle after it is taken and stays high up to and including the single cycle in which `done` is high. `busy` falls in the next cycle. A `start` seen while busy has no effect.
- R3: The write strobes of one operation carry, in order: 0x80 with CLE high, then five bytes with ALE high, then the data bytes, then 0x10 with CLE high, then 0x70 with CLE high. The five address bytes are col[7:0], col[15:8], row[7:0], row[15:8], row[23:16], with both addresses captured when `start` is taken.
- R4: Each operation raises exactly PAGE_BYTES (default 2048) byte requests and makes exactly PAGE_BYTES data strobes. The bus carries the byte returned for each request, in the order the bytes were delivered.
- R5: No data-phase write strobe falls while a byte request is still unanswered. A `byte_done` pulse that arrives when no byte is awaited is ignored.
- R6: `byte_req` is a one-cycle pulse. It is raised only while `nand_we_n` is high and the previous byte's strobe has completed.
- R7: Every write strobe stays low for at least max(T_WE_LOW, T_DS) clock cycles and high for at least T_WE_HIGH cycles between strobes.
- R8: `nand_ce_n` is low for the whole operation and high while idle. CLE and ALE are never high together. While `nand_ce_n` is high, both `nand_we_n` and `nand_re_n` are high.
- R9: After the confirm strobe the block waits T_WB cycles, then waits for the synchronised `nand_rb_n` to be high. It issues the status command and read strobe only after the line has returned high.
- R10: The status byte is sampled at the end of a read-enable low phase that lasts T_RE_LOW cycles. `pass` is the inverse of status bit 0, where 1 means the program failed. `pass` is valid from the `done` cycle and is held until the next `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a page-program operation (idle only) |
| col_addr | input | 16 | Column address, captured at start |
| row_addr | input | 24 | Row address, captured at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Program result, 1 = success |
| byte_req | output | 1 | One-cycle request for the next data byte |
| byte_done | input | 1 | Byte source pulse: `byte_in` holds the requested byte |
| byte_in | input | 8 | Data byte from the source |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_out | output | 8 | Bus data driven by the block |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Bus data read from the device |
| nand_rb_n | input | 1 | Ready/busy from the device, low = busy |

## Verification
The main sequence is tried under three operations. Each uses a different address and status pattern, and a byte source whose answer latency cycles through zero, one and two extra cycles. The varying latency shows whether strobes are truly paced by `byte_done` rather than by a fixed cadence. The second operation returns a failing status and receives a stray `start` mid-page. This tells result reporting apart from a stuck `pass`, and shows whether an ignored `start` would restart the command sequence. Running back-to-back operations against a source that wraps at the page size exposes any off-by-one in the byte count: the next page's data would then be shifted. A stray `byte_done` while idle shows that unsolicited handshakes cause no strobe.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;

    localparam int COL_BITS    = 16;
    localparam int ROW_BITS    = 24;
    localparam int ADDR_CYCLES = 5;

    localparam logic [7:0] OP_PROG_SETUP = 8'h80;
    localparam logic [7:0] OP_PROG_CONF  = 8'h10;
    localparam logic [7:0] OP_READ_STAT  = 8'h70;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_DREQ,
        S_DWAIT,
        S_DSTB,
        S_CONF,
        S_TWB,
        S_POLL,
        S_STAT,
        S_RDLO,
        S_RDHI,
        S_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_LOW,
        WP_HIGH
    } we_phase_t;

    typedef struct packed {
        logic [COL_BITS-1:0] col;
        logic [ROW_BITS-1:0] row;
    } page_addr_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Address byte order: column low, column high, row low, row mid, row high
    function automatic logic [7:0] addr_byte(input page_addr_t a, input logic [2:0] idx);
        logic [7:0] r;
        case (idx)
            3'd0:    r = a.col[7:0];
            3'd1:    r = a.col[15:8];
            3'd2:    r = a.row[7:0];
            3'd3:    r = a.row[15:8];
            default: r = a.row[23:16];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nps_we_engine.sv
module nps_we_engine
    import nand_pgm_pkg::*;
#(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2,
    parameter int CW       = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic we_n,
    output logic idle,
    output logic fin
);

    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

    we_phase_t     phase;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= WP_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                WP_IDLE: begin
                    if (go) begin
                        phase <= WP_LOW;
                        cnt   <= LOW_LAST;
                    end
                end
                WP_LOW: begin
                    if (cnt == '0) begin
                        phase <= WP_HIGH;
                        cnt   <= HIGH_LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                WP_HIGH: begin
                    if (cnt == '0) begin
                        phase <= WP_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= WP_IDLE;
            endcase
        end
    end

    assign we_n = (phase != WP_LOW);
    assign idle = (phase == WP_IDLE);
    assign fin  = (phase == WP_HIGH) && (cnt == '0);

endmodule

// File: rtl/nps_delay.sv
module nps_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expire
);

    logic          run;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= len - 1'b1;
        end else if (run) begin
            if (cnt == '0) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign expire = run && (cnt == '0);

endmodule

// File: rtl/nand_pgm_seq.sv
module nand_pgm_seq
    import nand_pgm_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int T_WE_LOW   = 2,
    parameter int T_WE_HIGH  = 2,
    parameter int T_DS       = 2,
    parameter int T_WB       = 4,
    parameter int T_RE_LOW   = 2,
    parameter int TW         = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [COL_BITS-1:0] col_addr,
    input  logic [ROW_BITS-1:0] row_addr,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic                byte_req,
    input  logic                byte_done,
    input  logic [7:0]          byte_in,
    output logic                nand_ce_n,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [7:0]          nand_dq_out,
    output logic                nand_dq_oe,
    input  logic [7:0]          nand_dq_in,
    input  logic                nand_rb_n
);

    localparam int            LOW_CYC   = imax(T_WE_LOW, T_DS);
    localparam int            CNT_W     = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(PAGE_BYTES - 1);
    localparam logic [2:0]    ADDR_LAST = 3'(ADDR_CYCLES - 1);

    seq_state_t       state, nxt;
    page_addr_t       addr_q;
    logic [2:0]       addr_idx;
    logic [CNT_W-1:0] byte_cnt;
    logic [7:0]       data_q;
    logic             pass_q;
    logic [1:0]       rb_sync;
    logic             rb_ready;

    logic             strobe_state;
    logic             eng_go, eng_idle, eng_fin;
    logic             tmr_load, tmr_exp;
    logic [TW-1:0]    tmr_len;

    // ready/busy crosses in from the device: two-flop synchroniser
    always_ff @(posedge clk) begin
        if (rst) begin
            rb_sync <= 2'b11;
        end else begin
            rb_sync <= {rb_sync[0], nand_rb_n};
        end
    end
    assign rb_ready = rb_sync[1];

    assign strobe_state = (state == S_CMD) || (state == S_ADDR) || (state == S_DSTB) ||
                          (state == S_CONF) || (state == S_STAT);
    assign eng_go = strobe_state && eng_idle;

    nps_we_engine #(
        .LOW_CYC (LOW_CYC),
        .HIGH_CYC(T_WE_HIGH),
        .CW      (TW)
    ) u_we (
        .clk (clk),
        .rst (rst),
        .go  (eng_go),
        .we_n(nand_we_n),
        .idle(eng_idle),
        .fin (eng_fin)
    );

    nps_delay #(
        .CW(TW)
    ) u_dly (
        .clk   (clk),
        .rst   (rst),
        .load  (tmr_load),
        .len   (tmr_len),
        .expire(tmr_exp)
    );

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_len  = '0;
        case (state)
            S_IDLE:  if (start) nxt = S_CMD;
            S_CMD:   if (eng_fin) nxt = S_ADDR;
            S_ADDR:  if (eng_fin && addr_idx == ADDR_LAST) nxt = S_DREQ;
            S_DREQ:  nxt = S_DWAIT;
            S_DWAIT: if (byte_done) nxt = S_DSTB;
            S_DSTB: begin
                if (eng_fin) nxt = (byte_cnt == LAST_BYTE) ? S_CONF : S_DREQ;
            end
            S_CONF: begin
                if (eng_fin) begin
                    nxt      = S_TWB;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(T_WB);
                end
            end
            S_TWB:   if (tmr_exp) nxt = S_POLL;
            S_POLL:  if (rb_ready) nxt = S_STAT;
            S_STAT: begin
                if (eng_fin) begin
                    nxt      = S_RDLO;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(T_RE_LOW);
                end
            end
            S_RDLO: begin
                if (tmr_exp) begin
                    nxt      = S_RDHI;
                    tmr_load = 1'b1;
                    tmr_len  = TW'(T_WE_HIGH);
                end
            end
            S_RDHI:  if (tmr_exp) nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            addr_idx <= '0;
            byte_cnt <= '0;
            data_q   <= '0;
            pass_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                addr_q   <= '{col: col_addr, row: row_addr};
                addr_idx <= '0;
                byte_cnt <= '0;
            end
            if (state == S_ADDR && eng_fin) begin
                addr_idx <= addr_idx + 1'b1;
            end
            if (state == S_DWAIT && byte_done) begin
                data_q <= byte_in;
            end
            if (state == S_DSTB && eng_fin) begin
                byte_cnt <= byte_cnt + 1'b1;
            end
            if (state == S_RDLO && tmr_exp) begin
                pass_q <= ~nand_dq_in[0];
            end
        end
    end

    always_comb begin
        case (state)
            S_CMD:   nand_dq_out = OP_PROG_SETUP;
            S_ADDR:  nand_dq_out = addr_byte(addr_q, addr_idx);
            S_DSTB:  nand_dq_out = data_q;
            S_CONF:  nand_dq_out = OP_PROG_CONF;
            S_STAT:  nand_dq_out = OP_READ_STAT;
            default: nand_dq_out = 8'h00;
        endcase
    end

    assign nand_dq_oe = strobe_state;
    assign nand_cle   = (state == S_CMD) || (state == S_CONF) || (state == S_STAT);
    assign nand_ale   = (state == S_ADDR);
    assign nand_re_n  = (state != S_RDLO);
    assign nand_ce_n  = (state == S_IDLE);
    assign byte_req   = (state == S_DREQ);
    assign busy       = (state != S_IDLE);
    assign done       = (state == S_FIN);
    assign pass       = pass_q;

endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
    parameter int MIN_LOW = 2
) (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic byte_req,
    input logic byte_done,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_rb_n
);

    logic [15:0] low_cnt;
    logic        outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt     <= '0;
            outstanding <= 1'b0;
        end else begin
            if (!nand_we_n) begin
                if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
            end
            if (byte_req)       outstanding <= 1'b1;
            else if (byte_done) outstanding <= 1'b0;
        end
    end

    assert_cle_ale_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_strobes_need_ce_R8: assert property (@(posedge clk) disable iff (rst)
        nand_ce_n |-> (nand_we_n && nand_re_n));

    assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    assert_req_single_R6: assert property (@(posedge clk) disable iff (rst)
        byte_req |=> !byte_req);

    assert_req_we_high_R6: assert property (@(posedge clk) disable iff (rst)
        byte_req |-> nand_we_n);

    assert_wait_for_byte_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(nand_we_n) && !nand_cle && !nand_ale) |-> !outstanding);

    assert_we_low_width_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (low_cnt >= 16'(MIN_LOW)));

    assert_read_after_ready_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_re_n) |-> nand_rb_n);

endmodule

bind nand_pgm_seq nps_checker #(
    .MIN_LOW(LOW_CYC)
) u_nps_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .byte_req (byte_req),
    .byte_done(byte_done),
    .nand_ce_n(nand_ce_n),
    .nand_cle (nand_cle),
    .nand_ale (nand_ale),
    .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n),
    .nand_rb_n(nand_rb_n)
);

// File: tb/test_nand_pgm_seq.sv
`timescale 1ns/1ps
module test_nand_pgm_seq;

    localparam int PAGE      = 2048;
    localparam int T_WE_LOW  = 2;
    localparam int T_WE_HIGH = 2;
    localparam int T_DS      = 3;
    localparam int T_WB      = 4;
    localparam int T_RE_LOW  = 2;
    localparam int LOW_MIN   = (T_WE_LOW > T_DS) ? T_WE_LOW : T_DS;
    localparam real TCK      = 8.0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] col_in = '0;
    logic [23:0] row_in = '0;
    logic        busy, done, pass, byte_req;
    logic        byte_done;
    logic [7:0]  byte_in;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out, nand_dq_in;
    logic        nand_rb_n;

    logic        status_fail = 1'b0;
    logic        inject = 1'b0;
    bit          started = 1'b0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          req_cnt = 0;
    int          n_strobe = 0;
    int          conf_evt = 0;
    int          conf_ack;
    int          rb_cnt;
    int          src_idx;
    int          lat;
    bit          pend;
    realtime     t_fall, t_rise;
    realtime     t_re_fall;
    bit          have_rise = 1'b0;
    logic [9:0]  exp_q[$];

    always #4 clk = ~clk;

    assign nand_dq_in = {7'b1110000, status_fail};

    nand_pgm_seq #(
        .PAGE_BYTES(PAGE),
        .T_WE_LOW  (T_WE_LOW),
        .T_WE_HIGH (T_WE_HIGH),
        .T_DS      (T_DS),
        .T_WB      (T_WB),
        .T_RE_LOW  (T_RE_LOW),
        .TW        (8)
    ) i_nand_pgm_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .col_addr   (col_in),
        .row_addr   (row_in),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .byte_req   (byte_req),
        .byte_done  (byte_done),
        .byte_in    (byte_in),
        .nand_ce_n  (nand_ce_n),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_we_n  (nand_we_n),
        .nand_re_n  (nand_re_n),
        .nand_dq_out(nand_dq_out),
        .nand_dq_oe (nand_dq_oe),
        .nand_dq_in (nand_dq_in),
        .nand_rb_n  (nand_rb_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + (i >> 5)) ^ 8'h5A);
    endfunction

    // Byte source model: circular buffer, one byte per request, varying latency
    always @(posedge clk) begin
        byte_done <= 1'b0;
        if (rst) begin
            src_idx <= 0;
            pend    <= 1'b0;
            lat     <= 0;
            byte_in <= 8'h00;
        end else if (inject) begin
            byte_done <= 1'b1;
            byte_in   <= 8'hEE;
        end else if (byte_req) begin
            chk(!pend && nand_we_n, "R6 request while busy strobing", {pend, nand_we_n}, 32'h1);
            req_cnt <= req_cnt + 1;
            pend    <= 1'b1;
            lat     <= src_idx % 3;
        end else if (pend) begin
            if (lat == 0) begin
                byte_in   <= pat(src_idx);
                byte_done <= 1'b1;
                pend      <= 1'b0;
                src_idx   <= (src_idx == PAGE - 1) ? 0 : src_idx + 1;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // Ready/busy model: goes busy after the confirm strobe for 30 cycles
    always @(posedge clk) begin
        if (rst) begin
            nand_rb_n <= 1'b1;
            rb_cnt    <= 0;
            conf_ack  <= 0;
        end else if (conf_evt != conf_ack) begin
            conf_ack  <= conf_evt;
            nand_rb_n <= 1'b0;
            rb_cnt    <= 30;
        end else if (rb_cnt != 0) begin
            rb_cnt <= rb_cnt - 1;
            if (rb_cnt == 1) nand_rb_n <= 1'b1;
        end
    end

    // Scoreboard monitor on write strobes
    always @(posedge nand_we_n) begin
        if (started) begin
            logic [9:0] got;
            logic [9:0] want;
            got = {nand_cle, nand_ale, nand_dq_out};
            n_strobe++;
            t_rise    = $realtime;
            have_rise = 1'b1;
            chk((t_rise - t_fall) / TCK >= LOW_MIN, "R7 WE low width",
                32'(int'((t_rise - t_fall) / TCK)), 32'(LOW_MIN));
            chk(nand_ce_n == 1'b0, "R8 CE during strobe", 32'(nand_ce_n), 32'h0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected strobe", 32'(got), 32'h3FF);
            end else begin
                want = exp_q.pop_front();
                chk(got == want, (want[9] || want[8]) ? "R3 cmd/addr strobe" : "R4 data strobe",
                    32'(got), 32'(want));
            end
            if (got == {2'b10, 8'h10}) conf_evt++;
            if (got == {2'b10, 8'h70}) begin
                chk(nand_rb_n == 1'b1, "R9 status after ready", 32'(nand_rb_n), 32'h1);
            end
        end
    end

    always @(negedge nand_we_n) begin
        if (started) begin
            t_fall = $realtime;
            if (have_rise) begin
                chk((t_fall - t_rise) / TCK >= T_WE_HIGH, "R7 WE high width",
                    32'(int'((t_fall - t_rise) / TCK)), 32'(T_WE_HIGH));
            end
        end
    end

    always @(negedge nand_re_n) begin
        if (started) begin
            t_re_fall = $realtime;
            chk(nand_rb_n == 1'b1, "R9 read while busy", 32'(nand_rb_n), 32'h1);
        end
    end

    always @(posedge nand_re_n) begin
        if (started) begin
            chk(($realtime - t_re_fall) / TCK >= T_RE_LOW, "R10 RE low width",
                32'(int'(($realtime - t_re_fall) / TCK)), 32'(T_RE_LOW));
        end
    end

    task automatic push_op(input logic [15:0] col, input logic [23:0] row);
        exp_q.push_back({2'b10, 8'h80});
        exp_q.push_back({2'b01, col[7:0]});
        exp_q.push_back({2'b01, col[15:8]});
        exp_q.push_back({2'b01, row[7:0]});
        exp_q.push_back({2'b01, row[15:8]});
        exp_q.push_back({2'b01, row[23:16]});
        for (int i = 0; i < PAGE; i++) exp_q.push_back({2'b00, pat(i)});
        exp_q.push_back({2'b10, 8'h10});
        exp_q.push_back({2'b10, 8'h70});
    endtask

    task automatic run_op(input bit fail, input logic [15:0] col, input logic [23:0] row, input bit poke);
        int req_base;
        int cyc;
        status_fail = fail;
        req_base    = req_cnt;
        push_op(col, row);
        col_in = col;
        row_in = row;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'h1);
        chk(nand_ce_n == 1'b0, "R8 CE low in operation", 32'(nand_ce_n), 32'h0);
        if (poke) begin
            repeat (60) @(negedge clk);
            col_in = 16'hFFFF;
            row_in = 24'hFFFFFF;
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R2 start while busy", 32'(busy), 32'h1);
        end
        cyc = 0;
        while (!done && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R2 done pulse", 32'(done), 32'h1);
        chk(busy == 1'b1, "R2 busy with done", 32'(busy), 32'h1);
        chk(pass == !fail, "R10 pass result", 32'(pass), 32'(!fail));
        chk(exp_q.size() == 0, "R3 all strobes seen", 32'(exp_q.size()), 32'h0);
        chk(req_cnt - req_base == PAGE, "R4 request count", 32'(req_cnt - req_base), 32'(PAGE));
        @(negedge clk);
        chk(done == 1'b0, "R2 done one cycle", 32'(done), 32'h0);
        chk(busy == 1'b0, "R2 busy falls", 32'(busy), 32'h0);
        chk(nand_ce_n == 1'b1, "R8 CE high when idle", 32'(nand_ce_n), 32'h1);
        repeat (5) @(negedge clk);
        chk(pass == !fail, "R10 pass held", 32'(pass), 32'(!fail));
    endtask

    initial begin
        int s0;
        repeat (5) @(negedge clk);
        rst     = 1'b0;
        started = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(nand_ce_n == 1'b1, "R1 CE", 32'(nand_ce_n), 32'h1);
        chk(nand_we_n == 1'b1, "R1 WE", 32'(nand_we_n), 32'h1);
        chk(nand_re_n == 1'b1, "R1 RE", 32'(nand_re_n), 32'h1);
        chk({nand_cle, nand_ale} == 2'b00, "R1 CLE/ALE", 32'({nand_cle, nand_ale}), 32'h0);
        chk({busy, done, byte_req} == 3'b000, "R1 busy/done/req", 32'({busy, done, byte_req}), 32'h0);

        // R5: unsolicited byte_done while idle
        s0     = n_strobe;
        inject = 1'b1;
        @(negedge clk);
        inject = 1'b0;
        repeat (10) @(negedge clk);
        chk(n_strobe == s0, "R5 stray done no strobe", 32'(n_strobe), 32'(s0));
        chk(req_cnt == 0, "R5 stray done no request", 32'(req_cnt), 32'h0);
        chk(busy == 1'b0, "R5 stray done stays idle", 32'(busy), 32'h0);

        run_op(1'b0, 16'h0123, 24'h456789, 1'b0);
        run_op(1'b1, 16'hA55A, 24'h00C3F0, 1'b1);
        run_op(1'b0, 16'h7E01, 24'hFE1002, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule